// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block collects up to 128 level-sensitive interrupt request lines and presents them to a processor as one interrupt output plus a sorted interrupt number. Each line has a mask bit. The mask bits sit in 32-bit banks. Software changes them only by writing ones to a per-bank set alias or a per-bank clear alias. Per bank, software can read the current mask and the masked pending status (input level with the masked lines removed).

When any unmasked line is high and the controller is idle, it picks the lowest-numbered pending line and runs a fixed-length sort window. At the end of the window it publishes the line number in the sorted-number register and raises the interrupt output. If the chosen line stopped being pending during the window, because it dropped or was masked, the published value carries a spurious signature in its upper bits. The output stays high, and the published number stays frozen, until software writes an acknowledge. Only then can a new sort begin.

A soft reset, started through a configuration bit, returns the block to its power-up state and reports completion through a status bit. A read-only revision register identifies the block. A few configuration registers, including one 8-bit priority field per line, are kept only as storage with no effect on sorting.

Top module: `vec_intc`

## Requirements
- R1: After reset every mask bit is 1, all pending words read 0, `irq_out` is 0, the sorted-number register (0x40) reads 0 and bit 0 of the status register (0x14) reads 1. With every line masked, no input level raises `irq_out`.
- R2: Bank b has its mask at 0x84+0x20*b, its clear alias at 0x88+0x20*b and its set alias at 0x8C+0x20*b. Writing a word to the set alias sets the mask bits where that word has ones. Writing a word to the clear alias clears the mask bits where it has ones. Zero bits leave the mask unchanged. The mask address itself ignores writes.
- R3: The pending word of bank b at 0x98+0x20*b reads input level AND NOT mask for lines 32*b to 32*b+31, with line 32*b in bit 0.
- R4: When several unmasked lines are pending, the lowest-numbered one wins. After a clean sort, register 0x40 holds its number in bits 6:0 and zeros in bits 31:7.
- R5: `irq_out` rises SORT_CYCLES clock cycles after the capture edge. The capture edge is the first rising edge at which the idle controller sees a pending line, which makes it the (SORT_CYCLES+1)th edge counting the capture edge.
- R6: If the winning line stops being pending before its sort window ends, register 0x40 reads all ones in bits 31:7 and the winner's number in bits 6:0, and `irq_out` still rises. Bits 31:7 are always all zero or all one.
- R7: A write with bit 0 set to the control register at 0x48 acknowledges. `irq_out` is low from the next edge on, and a new sort may begin on the edge after that. A write with bit 0 clear leaves `irq_out` high.
- R8: While `irq_out` is high, register 0x40 does not change, even when lower-numbered lines become pending.
- R9: Writing a word with bit 1 set to 0x10 starts a soft reset. `irq_out` drops at once. Bit 0 of 0x14 reads 0 for RESET_CYCLES cycles after the write edge and then 1. Masks return to all ones and the storage registers return to 0. Bus writes are ignored while the reset is running.
- R10: Register 0x00 reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, with zeros above.
- R11: The registers at 0x10 (every bit except bit 1, which reads 0), 0x4C, 0x50 and 0x68 store full 32-bit words. The per-line words at 0x100+4*n store bits 7:0 and read zeros above. None of them affects sorting. Offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt requests |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Every line is raised alone in turn. This checks, for each line number, the published number and the exact number of cycles to the interrupt, so an off-by-one in the window or a bad encoder input shows up. The lines are then raised in pairs at spread-out distances, which shows whether the encoder favours the lower or the higher number. A lower line is raised while an interrupt is held, which separates a frozen result from a live one. A line is dropped and another is masked in mid-window, which separates the spurious path from a clean sort. Fixed bit patterns, run against chosen masks on every bank, expose swapped set and clear aliases or a wrong bank stride.

// File: rtl/vec_intc_pkg.sv
// Package vec_intc_pkg
// Register offsets, field positions and shared types of the interrupt
// controller. Offsets are byte addresses on a word-aligned bus.
package vec_intc_pkg;

    localparam int WORD_W       = 32;
    localparam int BANK_W       = 32;
    localparam int WIN_W        = 7;
    localparam int SPUR_W       = WORD_W - WIN_W;

    localparam int OFF_REV      = 'h000;
    localparam int OFF_SYSCFG   = 'h010;
    localparam int OFF_SYSSTAT  = 'h014;
    localparam int OFF_SIR      = 'h040;
    localparam int OFF_CTRL     = 'h048;
    localparam int OFF_PROT     = 'h04C;
    localparam int OFF_IDLE     = 'h050;
    localparam int OFF_THRESH   = 'h068;
    localparam int OFF_MASK     = 'h084;
    localparam int OFF_MCLR     = 'h088;
    localparam int OFF_MSET     = 'h08C;
    localparam int OFF_PEND     = 'h098;
    localparam int BANK_STRIDE  = 'h020;
    localparam int OFF_PRIO     = 'h100;

    localparam int CTRL_ACK_BIT = 0;
    localparam int SRST_BIT     = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_HELD = 2'd2
    } sort_state_t;

endpackage

// File: rtl/vec_intc_bank.sv
// Module vec_intc_bank
// One 32-line mask bank. The mask changes only through write-one set and
// clear strobes. It also forms the masked pending word of its lines.
// Assumes set_we and clr_we are never high together (distinct addresses).
module vec_intc_bank
    import vec_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] lines,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] pend
);

    logic [BANK_W-1:0] set_bits;
    logic [BANK_W-1:0] clr_bits;

    // Select which mask bits this cycle's write sets or clears.
    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Mask state: all ones out of reset, then set/clear by write-one strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask <= '1;
        end else begin
            mask <= (mask | set_bits) & ~clr_bits;
        end
    end

    // Masked pending status of the bank.
    assign pend = lines & ~mask;

endmodule

// File: rtl/vec_intc_sorter.sv
// Module vec_intc_sorter
// Picks the lowest-numbered pending line, waits SORT_CYCLES cycles while
// checking that the winner stays pending, then publishes the number (with a
// spurious signature if the winner was lost) and holds the interrupt until
// acknowledged. Assumes NUM_LINES <= 128 and SORT_CYCLES >= 1.
module vec_intc_sorter
    import vec_intc_pkg::*;
#(
    parameter int NUM_LINES   = 96,
    parameter int SORT_CYCLES = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_LINES-1:0] pend,
    input  logic                 ack,
    output logic                 irq,
    output logic                 sorting,
    output logic [WORD_W-1:0]    sir
);

    localparam int CNT_W = $clog2(SORT_CYCLES + 1);

    sort_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_d;
    logic             any_d;
    logic             spur_q;
    logic             lost;

    // Priority encoder: lowest-numbered pending line wins.
    always_comb begin
        any_d = 1'b0;
        win_d = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any_d = 1'b1;
                win_d = WIN_W'(i);
            end
        end
    end

    // The captured winner has stopped being pending (dropped or masked).
    assign lost = !pend[win_q];

    // Sort sequencer: idle -> sorting window -> held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            win_q  <= '0;
            spur_q <= 1'b0;
            sir    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (any_d) begin
                        state  <= ST_SORT;
                        cnt    <= CNT_W'(SORT_CYCLES - 1);
                        win_q  <= win_d;
                        spur_q <= 1'b0;
                    end
                end
                ST_SORT: begin
                    if (cnt == '0) begin
                        state <= ST_HELD;
                        sir   <= {(spur_q || lost) ? {SPUR_W{1'b1}} : {SPUR_W{1'b0}}, win_q};
                    end else begin
                        cnt    <= cnt - 1'b1;
                        spur_q <= spur_q || lost;
                    end
                end
                ST_HELD: begin
                    if (ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign irq     = (state == ST_HELD);
    assign sorting = (state == ST_SORT);

endmodule

// File: rtl/vec_intc_srst.sv
// Module vec_intc_srst
// Soft-reset sequencer: a start pulse holds busy high for RESET_CYCLES
// cycles. Assumes RESET_CYCLES >= 1 and start only arrives while idle.
module vec_intc_srst #(
    parameter int RESET_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int RC_W = $clog2(RESET_CYCLES + 1);

    logic [RC_W-1:0] cnt;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= RC_W'(RESET_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/vec_intc.sv
// Module vec_intc (top)
// Memory-mapped vectored interrupt controller for level-sensitive lines.
// Register decode, storage-only registers, mask banks, sorter and soft
// reset. Assumes NUM_LINES is 96 or 128 (a multiple of 32, at most 128),
// word-aligned accesses, and ADDR_W wide enough for 0x100+4*NUM_LINES.
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NUM_LINES    = 96,
    parameter int ADDR_W       = 12,
    parameter int SORT_CYCLES  = 10,
    parameter int RESET_CYCLES = 4,
    parameter int REV_MAJOR    = 5,
    parameter int REV_MINOR    = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_out
);

    localparam int NUM_BANKS = NUM_LINES / BANK_W;
    localparam int PW        = $clog2(NUM_LINES);

    logic                 wr_ok;
    logic                 srst_go;
    logic                 srst_busy;
    logic                 clr_all;
    logic                 ack;
    logic [NUM_LINES-1:0] mask_all;
    logic [NUM_LINES-1:0] pend_all;
    logic [WORD_W-1:0]    sir_w;
    logic                 sort_busy;
    logic [WORD_W-1:0]    syscfg_q;
    logic [WORD_W-1:0]    prot_q;
    logic [WORD_W-1:0]    idle_q;
    logic [WORD_W-1:0]    thresh_q;
    logic [7:0]           prio_q [NUM_LINES];
    logic                 prio_hit;
    logic [PW-1:0]        prio_idx;

    // Write qualification, soft-reset start and acknowledge strobes.
    always_comb begin
        wr_ok   = bus_we && !srst_busy;
        srst_go = wr_ok && (bus_addr == ADDR_W'(OFF_SYSCFG)) && bus_wdata[SRST_BIT];
        ack     = wr_ok && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_ACK_BIT];
        clr_all = srst_go || srst_busy;
    end

    vec_intc_srst #(
        .RESET_CYCLES(RESET_CYCLES)
    ) u_srst (
        .clk  (clk),
        .rst_n(rst_n),
        .start(srst_go),
        .busy (srst_busy)
    );

    // One mask bank per 32 lines, each with its own set/clear aliases.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic set_we;
        logic clr_we;
        assign set_we = wr_ok && (bus_addr == ADDR_W'(OFF_MSET + BANK_STRIDE * b));
        assign clr_we = wr_ok && (bus_addr == ADDR_W'(OFF_MCLR + BANK_STRIDE * b));
        vec_intc_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .set_we(set_we),
            .clr_we(clr_we),
            .wdata (bus_wdata),
            .lines (irq_lines[b*BANK_W +: BANK_W]),
            .mask  (mask_all[b*BANK_W +: BANK_W]),
            .pend  (pend_all[b*BANK_W +: BANK_W])
        );
    end

    vec_intc_sorter #(
        .NUM_LINES  (NUM_LINES),
        .SORT_CYCLES(SORT_CYCLES)
    ) u_sorter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_all),
        .pend   (pend_all),
        .ack    (ack),
        .irq    (irq_out),
        .sorting(sort_busy),
        .sir    (sir_w)
    );

    // Storage-only configuration words; the reset-start bit is not kept.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            syscfg_q <= '0;
            prot_q   <= '0;
            idle_q   <= '0;
            thresh_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFF_SYSCFG)) syscfg_q <= bus_wdata & ~(WORD_W'(1) << SRST_BIT);
            if (bus_addr == ADDR_W'(OFF_PROT))   prot_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_IDLE))   idle_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_THRESH)) thresh_q <= bus_wdata;
        end
    end

    // Per-line 8-bit storage fields at 0x100 + 4*n.
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_LINES; n++) begin
            if (!rst_n || clr_all) begin
                prio_q[n] <= '0;
            end else if (wr_ok && (bus_addr == ADDR_W'(OFF_PRIO + 4 * n))) begin
                prio_q[n] <= bus_wdata[7:0];
            end
        end
    end

    // Address window and index of the per-line storage fields.
    always_comb begin
        prio_hit = (bus_addr >= ADDR_W'(OFF_PRIO)) &&
                   (bus_addr <  ADDR_W'(OFF_PRIO + 4 * NUM_LINES)) &&
                   (bus_addr[1:0] == 2'b00);
        prio_idx = bus_addr[PW+1:2] - PW'(OFF_PRIO / 4);
    end

    // Read multiplexer; unmapped and write-only offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_REV))     bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
        if (bus_addr == ADDR_W'(OFF_SYSCFG))  bus_rdata = syscfg_q;
        if (bus_addr == ADDR_W'(OFF_SYSSTAT)) bus_rdata = {31'd0, !srst_busy};
        if (bus_addr == ADDR_W'(OFF_SIR))     bus_rdata = sir_w;
        if (bus_addr == ADDR_W'(OFF_PROT))    bus_rdata = prot_q;
        if (bus_addr == ADDR_W'(OFF_IDLE))    bus_rdata = idle_q;
        if (bus_addr == ADDR_W'(OFF_THRESH))  bus_rdata = thresh_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(OFF_MASK + BANK_STRIDE * b)) bus_rdata = mask_all[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(OFF_PEND + BANK_STRIDE * b)) bus_rdata = pend_all[b*BANK_W +: BANK_W];
        end
        if (prio_hit) bus_rdata = {24'd0, prio_q[prio_idx]};
    end

endmodule

// File: rtl/vec_intc_checker.sv
// Module vec_intc_checker
// Concurrent properties of vec_intc, attached to every instance by bind.
// Bus strobes are re-decoded from the ports; state comes from top nets.
module vec_intc_checker
    import vec_intc_pkg::*;
#(
    parameter int NUM_LINES = 96,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic                 irq_out,
    input logic [WORD_W-1:0]    sir,
    input logic                 sorting,
    input logic                 srst_busy,
    input logic [NUM_LINES-1:0] mask_all
);

    logic ack_wr;
    logic srst_wr;
    logic mset_wr;
    logic mclr_wr;

    // Bus strobes seen from the ports.
    always_comb begin
        ack_wr  = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_ACK_BIT];
        srst_wr = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFF_SYSCFG)) && bus_wdata[SRST_BIT];
        mset_wr = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFF_MSET));
        mclr_wr = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFF_MCLR));
    end

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mset_wr |=> ((mask_all[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_wr |=> ((mask_all[31:0] & $past(bus_wdata)) == '0));

    assert_rise_after_sort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(sorting));

    assert_spur_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sir[31:7] == '0) || (&sir[31:7]));

    assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack_wr && !srst_wr) |=> irq_out);

    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack_wr) |=> !irq_out);

    assert_sir_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack_wr && !srst_wr) |=> $stable(sir));

    assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (!irq_out && (&mask_all)));

    assert_busy_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (&mask_all));

endmodule

bind vec_intc vec_intc_checker #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
) u_vec_intc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .irq_out  (irq_out),
    .sir      (sir_w),
    .sorting  (sort_busy),
    .srst_busy(srst_busy),
    .mask_all (mask_all)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
// Bench for vec_intc: sweeps over all lines and line pairs, plus mask,
// hold, spurious, storage and soft-reset cases. Inputs change at negedge.
module vec_intc_bench;

    localparam int NL = 96;
    localparam int NB = NL / 32;
    localparam int SC = 10;
    localparam int RC = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] lines;
    logic          irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vec_intc #(
        .NUM_LINES(NL), .ADDR_W(AW), .SORT_CYCLES(SC),
        .RESET_CYCLES(RC), .REV_MAJOR(5), .REV_MINOR(0)
    ) u_vec_intc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(lines), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Tasks start and end just after a falling edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Count rising edges until irq_out is seen high (gives up after 60).
    task automatic wait_irq(output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (irq_out) break;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          n;
        rst_n     = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        lines     = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int b = 0; b < NB; b++) begin
            rd('h84 + 'h20 * b, d); check("R1 mask reset", d, 32'hFFFF_FFFF);
            rd('h98 + 'h20 * b, d); check("R1 pending reset", d, 32'd0);
        end
        check("R1 irq reset", {31'd0, irq_out}, 32'd0);
        rd('h14, d); check("R1 status reset", d, 32'd1);
        rd('h40, d); check("R1 sir reset", d, 32'd0);

        // R10: revision
        rd('h00, d); check("R10 revision", d, 32'h0000_0050);

        // R1/R3: all masked, no interrupt, nothing pending
        lines = '1;
        cycles(SC + 10);
        check("R1 masked no irq", {31'd0, irq_out}, 32'd0);
        for (int b = 0; b < NB; b++) begin
            rd('h98 + 'h20 * b, d); check("R3 masked pending", d, 32'd0);
        end
        lines = '0;

        // R2: set/clear aliases per bank
        for (int b = 0; b < NB; b++) begin
            wr('h88 + 'h20 * b, 32'h0000_00F0 << b);
            rd('h84 + 'h20 * b, d); check("R2 clear", d, ~(32'h0000_00F0 << b));
            wr('h8C + 'h20 * b, 32'h0000_0010 << b);
            rd('h84 + 'h20 * b, d); check("R2 set", d, ~(32'h0000_00E0 << b));
            wr('h88 + 'h20 * b, 32'd0);
            rd('h84 + 'h20 * b, d); check("R2 zero clear", d, ~(32'h0000_00E0 << b));
            wr('h84 + 'h20 * b, 32'd0);
            rd('h84 + 'h20 * b, d); check("R2 mask read-only", d, ~(32'h0000_00E0 << b));
            wr('h8C + 'h20 * b, 32'hFFFF_FFFF);
        end

        // R3: pending = level & ~mask per bank
        for (int b = 0; b < NB; b++) begin
            logic [31:0] lv;
            logic [31:0] mk;
            lv = 32'hA5C3_0F96 ^ (32'h1111_1111 * b);
            mk = 32'h00FF_F00F << b;
            lines[b*32 +: 32] = lv;
            wr('h88 + 'h20 * b, 32'hFFFF_FFFF);
            wr('h8C + 'h20 * b, mk);
            rd('h98 + 'h20 * b, d); check("R3 pending pattern", d, lv & ~mk);
        end
        lines = '0;
        cycles(SC + 5);
        wr('h48, 32'd1);
        cycles(2);

        // Unmask everything
        for (int b = 0; b < NB; b++) wr('h88 + 'h20 * b, 32'hFFFF_FFFF);

        // R4/R5/R7: every line alone
        for (int i = 0; i < NL; i++) begin
            lines = '0;
            lines[i] = 1'b1;
            wait_irq(n);
            check($sformatf("R5 latency line %0d", i), n, SC + 1);
            rd('h40, d); check($sformatf("R4 number line %0d", i), d, i);
            lines = '0;
            wr('h48, 32'd1);
            check("R7 ack drops irq", {31'd0, irq_out}, 32'd0);
        end

        // R4: pairs, lowest wins
        for (int i = 0; i < NL; i++) begin
            int j;
            j = (i * 37 + 11) % NL;
            if (j != i) begin
                lines = '0;
                lines[i] = 1'b1;
                lines[j] = 1'b1;
                wait_irq(n);
                rd('h40, d); check($sformatf("R4 pair %0d,%0d", i, j), d, (i < j) ? i : j);
                lines = '0;
                wr('h48, 32'd1);
            end
        end

        // R8/R7: hold while a lower line arrives; zero write does not ack
        lines = '0;
        lines[20] = 1'b1;
        wait_irq(n);
        lines[3] = 1'b1;
        cycles(SC + 5);
        check("R8 irq held", {31'd0, irq_out}, 32'd1);
        rd('h40, d); check("R8 sir frozen", d, 32'd20);
        wr('h48, 32'd0);
        check("R7 zero write no ack", {31'd0, irq_out}, 32'd1);
        lines[20] = 1'b0;
        wr('h48, 32'd1);
        wait_irq(n);
        check("R7 resort latency", n, SC + 1);
        rd('h40, d); check("R7 resort number", d, 32'd3);
        lines = '0;
        wr('h48, 32'd1);

        // R6: winner drops mid-window
        lines[5] = 1'b1;
        cycles(3);
        lines[5] = 1'b0;
        wait_irq(n);
        check("R6 irq on drop", {31'd0, irq_out}, 32'd1);
        rd('h40, d); check("R6 spurious on drop", d, 32'hFFFF_FF85);
        wr('h48, 32'd1);

        // R6: winner masked mid-window
        lines[7] = 1'b1;
        cycles(2);
        wr('h8C, 32'h0000_0080);
        wait_irq(n);
        rd('h40, d); check("R6 spurious on mask", d, 32'hFFFF_FF87);
        lines = '0;
        wr('h48, 32'd1);
        wr('h88, 32'h0000_0080);

        // R11: storage-only registers and unmapped reads
        wr('h10, 32'hDEAD_BEEF & ~32'h2);
        rd('h10, d); check("R11 syscfg", d, 32'hDEAD_BEED);
        wr('h4C, 32'hA5A5_0001);
        rd('h4C, d); check("R11 prot", d, 32'hA5A5_0001);
        wr('h50, 32'h0000_0002);
        rd('h50, d); check("R11 idle", d, 32'h0000_0002);
        wr('h68, 32'h0000_00FF);
        rd('h68, d); check("R11 thresh", d, 32'h0000_00FF);
        for (int i = 0; i < NL; i += 19) begin
            wr('h100 + 4 * i, 32'h0000_0100 | i);
            rd('h100 + 4 * i, d); check("R11 prio field", d, i & 'hFF);
        end
        rd('h44, d); check("R11 unmapped", d, 32'd0);
        rd('h100 + 4 * NL, d); check("R11 past prio", d, 32'd0);
        rd('h88, d); check("R11 clear alias reads 0", d, 32'd0);
        lines[9] = 1'b1;
        wait_irq(n);
        rd('h40, d); check("R11 no effect on sort", d, 32'd9);

        // R9: soft reset while holding an interrupt
        wr('h10, 32'h0000_0002);
        check("R9 irq dropped", {31'd0, irq_out}, 32'd0);
        n = 0;
        rd('h14, d);
        while (d[0] == 1'b0 && n < 50) begin
            cycles(1);
            n++;
            rd('h14, d);
        end
        check("R9 reset duration", n, RC);
        for (int b = 0; b < NB; b++) begin
            rd('h84 + 'h20 * b, d); check("R9 masks restored", d, 32'hFFFF_FFFF);
        end
        rd('h4C, d); check("R9 prot cleared", d, 32'd0);
        rd('h10, d); check("R9 syscfg cleared", d, 32'd0);
        rd('h100, d); check("R9 prio cleared", d, 32'd0);
        cycles(SC + 3);
        check("R9 masked after reset", {31'd0, irq_out}, 32'd0);
        lines = '0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule